// File: doc/BRIEF.md
# Display FIFO Flow and Sync Controller

This block decides when pixel data may move from a display channel into the output FIFO that feeds a serial panel formatter, and which event launches each frame. Software programs it through a small register port: a control word carrying the flow request and the mode bits, a line width from which the FIFO watermark is derived, a write-one-to-clear event register and an interrupt mask. The FIFO storage reports its occupancy. The block returns a fetch enable, a FIFO-empty flag, a frame-start pulse, the watermark and an interrupt line.

Two update styles are supported. In video mode the flow stays on and frames follow the formatter's own sync. In command mode a single frame is pushed on a software trigger, or on the panel's tearing-effect (TE) pulse when TE sync is chosen. In one-shot command mode every flow request adds one to a pending-frame count, and every TE event takes one away. When the count reaches zero the flow shuts itself off. Turning the flow off, by software or by the count, always passes through a drain phase. The readable flow bit stays set until the FIFO is empty.

The flow state machine has three states. IDLE: no fetch. RUN: fetch enabled and frames may launch. DRAIN: fetch stopped, waiting for an empty FIFO. Its transitions are: IDLE to RUN on an enable request; RUN to DRAIN on a disable request or when the one-shot count expires; DRAIN to IDLE when the FIFO level is zero; DRAIN to RUN on an enable request.

Top module: `display_flow_ctrl`

## Requirements
- R1: After reset the state is IDLE, `fetch_en` is 0, and the control, event, mask and line registers read 0. The pending count is 0.
- R2: A write to address 0 with bit 0 set is an enable request; with bit 0 clear it is a disable request. An enable request from IDLE enters RUN with a pending count of 1. In RUN it adds one, saturating at the maximum. A disable in RUN stops `fetch_en` from the next cycle and zeroes the count. `fetch_en` is high exactly in RUN.
- R3: Bit 0 of a read at address 0 is 1 in RUN and DRAIN. DRAIN is left for IDLE only at a clock edge where `fifo_level` is 0, and that exit sets event bit 1. An enable request in DRAIN returns to RUN with a count of 1.
- R4: `wmark` is the line width (address 1, bits 10:0) capped at 128 when the video bit (control bit 1) is set, and capped at 48 otherwise.
- R5: The sync source reads as hardware (address 4 bit 1) when video or TE sync (control bit 2) is set. The output sync reads as TE (address 4 bit 2) when TE sync is set. In RUN, `frame_start` follows the TE event under TE sync, `fmt_sync` in video mode without TE sync, and `sw_trig` otherwise. It is 0 outside RUN.
- R6: The TE pin passes through one register. An event is a rising edge of the pin XOR the polarity bit (control bit 4), so polarity 1 selects falling edges. Events occur only while capture enable (control bit 5) is 1. Each edge gives a one-cycle event.
- R7: With one-shot set (control bit 3) and video clear, each TE event in RUN decrements the pending count. Reaching zero enters DRAIN.
- R8: A TE event in IDLE or DRAIN changes no count. In video mode TE events never reduce the count or stop the flow.
- R9: Event bits are 0 = TE event, 1 = drain complete and 2 = frame launched. They read at address 2. Writing 1s there clears the matching bits, and a set in the same cycle wins. Address 3 holds the mask. `irq` is high while any set bit is unmasked.
- R10: `fifo_empty`, and bit 0 of address 4, are 1 exactly when `fifo_level` is 0. Address 4 bits 11:8 show the pending count.
- R11: When a control write and a TE event fall in the same cycle, the write is applied and the TE event is not counted, though event bit 0 still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| sw_trig | input | 1 | Software sync trigger pulse |
| fmt_sync | input | 1 | Sync pulse from the formatter |
| te_in | input | 1 | Tearing-effect pin from the panel |
| fifo_level | input | 10 | Current FIFO occupancy, 0 to 640 |
| fetch_en | output | 1 | Allows the channel to push pixels into the FIFO |
| fifo_empty | output | 1 | FIFO occupancy is zero |
| frame_start | output | 1 | One-cycle frame launch pulse |
| wmark | output | 11 | FIFO watermark level |
| irq | output | 1 | Interrupt: unmasked pending event |

## Verification
The bench targets the drain window. A design that dropped the readable flow bit at the disable write, or that left DRAIN with data still queued, would show the bit falling while `fifo_level` is non-zero. It also checks that the one-shot count saturates at its maximum and expires only on the last TE event; a wrapping or off-by-one count would end the flow too early or never. The bench drives TE edges with both polarities and with capture disabled, and it sends TE events while idle and in video mode, where any reduction in the count is an error. A control write that lands in the same cycle as a TE event separates a design that applies both from one that gives the write priority.

// File: rtl/display_flow_pkg.sv
package display_flow_pkg;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_RUN   = 2'd1,
        FL_DRAIN = 2'd2
    } flow_state_t;

    // register addresses
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_LINE = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_MASK = 3'd3;
    localparam logic [2:0] A_INFO = 3'd4;

    // event bit indices
    localparam int EV_TE    = 0;
    localparam int EV_DONE  = 1;
    localparam int EV_FRAME = 2;
    localparam int NUM_EV   = 3;

    // mode bits held from control word bits 5:1
    typedef struct packed {
        logic cap_en;
        logic te_pol;
        logic oneshot;
        logic te_sync;
        logic video;
    } mode_cfg_t;

endpackage

// File: rtl/te_capture.sv
module te_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic te_in,
    input  logic te_pol,
    input  logic cap_en,
    output logic te_evt
);
    logic act_q;
    logic act_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            act_d <= 1'b0;
        end else begin
            act_q <= te_in ^ te_pol;
            act_d <= act_q;
        end
    end

    assign te_evt = cap_en & act_q & ~act_d;

    // R6
    te_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        te_evt |=> !te_evt);

endmodule

// File: rtl/flow_fsm.sv
module flow_fsm
    import display_flow_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic              dis_req,
    input  logic              te_evt,
    input  logic              auto_clr,
    input  logic              fifo_zero,
    output flow_state_t       state,
    output logic [PEND_W-1:0] pend,
    output logic              drain_done
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

    flow_state_t       state_nx;
    logic [PEND_W-1:0] pend_nx;
    logic              te_take;

    assign te_take = te_evt & auto_clr & (pend != '0);

    always_comb begin
        state_nx = state;
        pend_nx  = pend;
        unique case (state)
            FL_IDLE: begin
                if (en_req) begin
                    state_nx = FL_RUN;
                    pend_nx  = PEND_ONE;
                end
            end
            FL_RUN: begin
                if (en_req) begin
                    pend_nx = (pend == PEND_MAX) ? PEND_MAX : pend + PEND_ONE;
                end else if (dis_req) begin
                    state_nx = FL_DRAIN;
                    pend_nx  = '0;
                end else if (te_take) begin
                    pend_nx = pend - PEND_ONE;
                    if (pend == PEND_ONE) state_nx = FL_DRAIN;
                end
            end
            FL_DRAIN: begin
                if (en_req) begin
                    state_nx = FL_RUN;
                    pend_nx  = PEND_ONE;
                end else if (fifo_zero) begin
                    state_nx = FL_IDLE;
                end
            end
            default: begin
                state_nx = FL_IDLE;
                pend_nx  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FL_IDLE;
            pend  <= '0;
        end else begin
            state <= state_nx;
            pend  <= pend_nx;
        end
    end

    always_comb begin
        drain_done = (state == FL_DRAIN) && !en_req && fifo_zero;
    end

    // R7
    run_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FL_RUN) |-> (pend != '0));

    // R8
    pend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FL_RUN) |-> (pend == '0));

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> (pend <= PEND_ONE));

endmodule

// File: rtl/event_status.sv
module event_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] stat,
    output logic [N-1:0] mask,
    output logic         irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
            mask <= '0;
        end else begin
            stat <= (stat & ~(clr_we ? clr_bits : '0)) | set;
            if (mask_we) mask <= mask_wdata;
        end
    end

    assign irq = |(stat & mask);

    // R9
    stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~$past(stat) & ~$past(set)) == '0));

endmodule

// File: rtl/display_flow_ctrl.sv
module display_flow_ctrl
    import display_flow_pkg::*;
#(
    parameter int FIFO_DEPTH = 640,
    parameter int LINE_W     = 11,
    parameter int PEND_W     = 4,
    parameter int VID_CAP    = 128,
    parameter int CMD_CAP    = 48,
    parameter int DATA_W     = 32,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sw_trig,
    input  logic              fmt_sync,
    input  logic              te_in,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              fetch_en,
    output logic              fifo_empty,
    output logic              frame_start,
    output logic [LINE_W-1:0] wmark,
    output logic              irq
);
    localparam logic [LINE_W-1:0] VCAP = LINE_W'(VID_CAP);
    localparam logic [LINE_W-1:0] CCAP = LINE_W'(CMD_CAP);

    mode_cfg_t         cfg;
    logic [LINE_W-1:0] line_w;
    logic              wr_ctrl, en_req, dis_req;
    logic              te_evt, sync_hw, sync_pick, flow_rd;
    flow_state_t       state;
    logic [PEND_W-1:0] pend;
    logic              drain_done;
    logic [NUM_EV-1:0] ev_set, stat, mask;
    logic [LINE_W-1:0] cap;

    assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
    assign en_req  = wr_ctrl &&  reg_wdata[0];
    assign dis_req = wr_ctrl && !reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg    <= '0;
            line_w <= '0;
        end else if (reg_we) begin
            if (reg_addr == A_CTRL) cfg    <= mode_cfg_t'(reg_wdata[5:1]);
            if (reg_addr == A_LINE) line_w <= reg_wdata[LINE_W-1:0];
        end
    end

    te_capture u_te (
        .clk    (clk),
        .rst_n  (rst_n),
        .te_in  (te_in),
        .te_pol (cfg.te_pol),
        .cap_en (cfg.cap_en),
        .te_evt (te_evt)
    );

    flow_fsm #(.PEND_W(PEND_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_req     (en_req),
        .dis_req    (dis_req),
        .te_evt     (te_evt),
        .auto_clr   (cfg.oneshot & ~cfg.video),
        .fifo_zero  (fifo_empty),
        .state      (state),
        .pend       (pend),
        .drain_done (drain_done)
    );

    assign sync_hw     = cfg.video | cfg.te_sync;
    assign sync_pick   = sync_hw ? (cfg.te_sync ? te_evt : fmt_sync) : sw_trig;
    assign fetch_en    = (state == FL_RUN);
    assign flow_rd     = (state != FL_IDLE);
    assign frame_start = fetch_en & sync_pick;
    assign fifo_empty  = (fifo_level == '0);

    assign cap   = cfg.video ? VCAP : CCAP;
    assign wmark = (line_w < cap) ? line_w : cap;

    always_comb begin
        ev_set           = '0;
        ev_set[EV_TE]    = te_evt;
        ev_set[EV_DONE]  = drain_done;
        ev_set[EV_FRAME] = frame_start;
    end

    event_status #(.N(NUM_EV)) u_ev (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (ev_set),
        .clr_we     (reg_we && (reg_addr == A_STAT)),
        .clr_bits   (reg_wdata[NUM_EV-1:0]),
        .mask_we    (reg_we && (reg_addr == A_MASK)),
        .mask_wdata (reg_wdata[NUM_EV-1:0]),
        .stat       (stat),
        .mask       (mask),
        .irq        (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata[5:0]          = {cfg, flow_rd};
            A_LINE: reg_rdata[LINE_W-1:0]   = line_w;
            A_STAT: reg_rdata[NUM_EV-1:0]   = stat;
            A_MASK: reg_rdata[NUM_EV-1:0]   = mask;
            A_INFO: begin
                reg_rdata[0]           = fifo_empty;
                reg_rdata[1]           = sync_hw;
                reg_rdata[2]           = cfg.te_sync;
                reg_rdata[8 +: PEND_W] = pend;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R3
    flow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flow_rd) |-> ($past(fifo_level) == '0));

    // R5
    frame_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !$past(fetch_en)) |-> $past(en_req));

endmodule

// File: tb/sim_display_flow_ctrl.sv
`timescale 1ns/1ps
module sim_display_flow_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        sw_trig = 1'b0;
    logic        fmt_sync = 1'b0;
    logic        te_in = 1'b0;
    logic [9:0]  fifo_level = 10'd0;
    logic        fetch_en, fifo_empty, frame_start, irq;
    logic [10:0] wmark;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    display_flow_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_trig(sw_trig),
        .fmt_sync(fmt_sync), .te_in(te_in), .fifo_level(fifo_level),
        .fetch_en(fetch_en), .fifo_empty(fifo_empty), .frame_start(frame_start),
        .wmark(wmark), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int m_st, m_pend, m_line, m_stat, m_mask;
    bit m_vid, m_tes, m_one, m_pol, m_cap, m_ts, m_td;

    function automatic bit te_evt_f();
        return m_cap && m_ts && !m_td;
    endfunction

    function automatic bit frame_f();
        bit src;
        if (m_vid || m_tes) src = m_tes ? te_evt_f() : fmt_sync;
        else src = sw_trig;
        return (m_st == 1) && src;
    endfunction

    function automatic int wmark_f();
        int c;
        c = m_vid ? 128 : 48;
        return (m_line < c) ? m_line : c;
    endfunction

    function automatic logic [31:0] rdata_f(input int a);
        logic [31:0] r;
        r = 32'd0;
        case (a)
            0: r = {26'd0, m_cap, m_pol, m_one, m_tes, m_vid, (m_st != 0)};
            1: r = 32'(m_line);
            2: r = 32'(m_stat);
            3: r = 32'(m_mask);
            4: begin
                r[0] = (fifo_level == 0);
                r[1] = m_vid || m_tes;
                r[2] = m_tes;
                r[11:8] = 4'(m_pend);
            end
            default: r = 32'd0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pend = 0; m_line = 0; m_stat = 0; m_mask = 0;
            m_vid = 0; m_tes = 0; m_one = 0; m_pol = 0; m_cap = 0;
            m_ts = 0; m_td = 0;
        end else begin
            bit te, fr, en, dis, done;
            int clr;
            te = te_evt_f();
            fr = frame_f();
            en = reg_we && reg_addr == 0 && reg_wdata[0];
            dis = reg_we && reg_addr == 0 && !reg_wdata[0];
            done = 0;
            case (m_st)
                0: if (en) begin m_st = 1; m_pend = 1; end
                1: begin
                    if (en) m_pend = (m_pend < 15) ? m_pend + 1 : 15;
                    else if (dis) begin m_st = 2; m_pend = 0; end
                    else if (te && m_one && !m_vid && m_pend != 0) begin
                        m_pend = m_pend - 1;
                        if (m_pend == 0) m_st = 2;
                    end
                end
                default: begin
                    if (en) begin m_st = 1; m_pend = 1; end
                    else if (fifo_level == 0) begin m_st = 0; done = 1; end
                end
            endcase
            clr = (reg_we && reg_addr == 2) ? int'(reg_wdata[2:0]) : 0;
            m_stat = (m_stat & ~clr) | (fr << 2) | (done << 1) | int'(te);
            m_td = m_ts;
            m_ts = te_in ^ m_pol;
            if (reg_we && reg_addr == 3) m_mask = int'(reg_wdata[2:0]);
            if (reg_we && reg_addr == 1) m_line = int'(reg_wdata[10:0]);
            if (reg_we && reg_addr == 0) begin
                m_vid = reg_wdata[1]; m_tes = reg_wdata[2]; m_one = reg_wdata[3];
                m_pol = reg_wdata[4]; m_cap = reg_wdata[5];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // every-cycle comparison, sampled 8 ns after the negative edge
    initial forever begin
        @(negedge clk);
        #8;
        if (rst_n && !ended) begin
            chk("R2 fetch_en",    32'(fetch_en),    32'(m_st == 1));
            chk("R5 frame_start", 32'(frame_start), 32'(frame_f()));
            chk("R9 irq",         32'(irq),         32'((m_stat & m_mask) != 0));
            chk("R4 wmark",       32'(wmark),       32'(wmark_f()));
            chk("R10 fifo_empty", 32'(fifo_empty),  32'(fifo_level == 0));
            chk("R3 reg_rdata",   reg_rdata,        rdata_f(int'(reg_addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] msk,
                          input logic [31:0] exp);
        @(negedge clk);
        reg_addr = 3'(a);
        #8;
        chk(tag, reg_rdata & msk, exp);
    endtask

    task automatic te_pulse();
        @(negedge clk); te_in = 1'b1;
        idle(2);        te_in = 1'b0;
        idle(3);
    endtask

    task automatic finish_run();
        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd_chk("R1 ctrl", 0, 32'hFFFF_FFFF, 32'd0);
        rd_chk("R1 stat", 2, 32'hFFFF_FFFF, 32'd0);
        rd_chk("R1 info pend", 4, 32'h0000_0F06, 32'd0);
        chk("R1 fetch_en", 32'(fetch_en), 32'd0);

        // R4 watermark
        wr(1, 100); wr(0, 0);
        #1 chk("R4 cmd cap", 32'(wmark), 32'd48);
        wr(0, 2);
        #1 chk("R4 video width", 32'(wmark), 32'd100);
        wr(1, 300);
        #1 chk("R4 video cap", 32'(wmark), 32'd128);
        wr(0, 0); wr(1, 20);
        #1 chk("R4 cmd width", 32'(wmark), 32'd20);

        // video streaming, R5 and R8
        fifo_level = 10'd3;
        wr(0, 32'h2B);
        #1 chk("R2 fetch on", 32'(fetch_en), 32'd1);
        rd_chk("R5 sync hw", 4, 32'h6, 32'h2);
        @(negedge clk); fmt_sync = 1'b1;
        #1 chk("R5 fmt frame", 32'(frame_start), 32'd1);
        @(negedge clk); fmt_sync = 1'b0;
        te_pulse(); te_pulse();
        rd_chk("R8 video keeps flow", 0, 32'h1, 32'h1);
        rd_chk("R8 video keeps pend", 4, 32'hF00, 32'h100);

        // R3 drain hold
        wr(0, 32'h0A);
        #1 chk("R2 fetch off", 32'(fetch_en), 32'd0);
        rd_chk("R3 drain holds bit", 0, 32'h1, 32'h1);
        idle(3);
        rd_chk("R3 still draining", 0, 32'h1, 32'h1);
        @(negedge clk); fifo_level = 10'd0;
        idle(1);
        rd_chk("R3 drained", 0, 32'h1, 32'h0);
        rd_chk("R3 done event", 2, 32'h2, 32'h2);
        wr(2, 7);
        rd_chk("R9 w1c", 2, 32'h7, 32'h0);

        // software sync command mode
        wr(3, 4); wr(0, 1);
        @(negedge clk); sw_trig = 1'b1;
        #1 chk("R5 sw frame", 32'(frame_start), 32'd1);
        @(negedge clk); sw_trig = 1'b0;
        #1 chk("R9 irq on", 32'(irq), 32'd1);
        @(negedge clk); fmt_sync = 1'b1;
        #1 chk("R5 fmt ignored in cmd", 32'(frame_start), 32'd0);
        @(negedge clk); fmt_sync = 1'b0;
        wr(2, 4);
        #1 chk("R9 irq off", 32'(irq), 32'd0);
        wr(0, 0); idle(2);

        // one-shot TE, R7 and R8
        wr(0, 32'h2D); wr(0, 32'h2D);
        rd_chk("R2 pend two", 4, 32'hF00, 32'h200);
        te_pulse();
        rd_chk("R7 pend one", 4, 32'hF00, 32'h100);
        rd_chk("R7 still on", 0, 32'h1, 32'h1);
        te_pulse();
        rd_chk("R7 auto off", 0, 32'h1, 32'h0);
        wr(2, 7);
        te_pulse();
        rd_chk("R8 idle te event seen", 2, 32'h1, 32'h1);
        rd_chk("R8 idle te no count", 4, 32'hF00, 32'h0);

        // R2 saturation
        for (int i = 0; i < 17; i++) wr(0, 32'h2D);
        rd_chk("R2 saturate", 4, 32'hF00, 32'hF00);
        wr(0, 32'h2C); idle(2);

        // R3 enable during drain
        fifo_level = 10'd4;
        wr(0, 1); wr(0, 0); wr(0, 1);
        rd_chk("R3 resume pend", 4, 32'hF00, 32'h100);
        #1 chk("R3 resume fetch", 32'(fetch_en), 32'd1);
        fifo_level = 10'd0;
        wr(0, 0); idle(2);

        // R6 capture disabled
        wr(0, 32'h0D); wr(2, 7);
        te_pulse();
        rd_chk("R6 cap off no event", 2, 32'h1, 32'h0);
        rd_chk("R6 cap off pend", 4, 32'hF00, 32'h100);
        wr(0, 0); idle(2);

        // R6 falling-edge polarity
        @(negedge clk); te_in = 1'b1;
        idle(3);
        wr(0, 32'h3D); wr(2, 7);
        @(negedge clk); te_in = 1'b0;
        idle(3);
        rd_chk("R6 falling edge event", 2, 32'h1, 32'h1);
        rd_chk("R6 falling edge ends flow", 0, 32'h1, 32'h0);
        wr(2, 7);
        @(negedge clk); te_in = 1'b1;
        idle(3);
        rd_chk("R6 rising ignored", 2, 32'h1, 32'h0);
        @(negedge clk); te_in = 1'b0;
        wr(0, 0); idle(3);

        // R11 write collides with TE event
        wr(0, 32'h2D); idle(2); wr(2, 7);
        @(negedge clk); te_in = 1'b1;
        wr(0, 32'h2D);
        rd_chk("R11 write wins", 4, 32'hF00, 32'h200);
        rd_chk("R11 te still flagged", 2, 32'h1, 32'h1);
        @(negedge clk); te_in = 1'b0;
        wr(0, 0); idle(3);

        finish_run();
    end

endmodule